// File: doc/BRIEF.md
# Speculative Load Violation Detector

This block sits beside one processor of a four-way chip multiprocessor that runs speculative threads. For every line of that processor's private L1 data cache it keeps three bits of speculation state: valid, read and pre-invalidated. It follows its own processor's loads and stores. It also snoops every store that another processor places on the shared write bus, together with that writer's processor number. A head pointer names the one non-speculative processor. Each processor's position in thread order is its distance from the head, counted modulo the processor count.

A snooped store from a thread that comes earlier in order invalidates the matching local line. If this thread already read that line speculatively, the block raises a sticky violation so that restart software can squash the thread. A snooped store from a later thread only marks the line as pre-invalidated. That line stays readable until this thread commits or restarts, and at that point it is dropped. A commit or restart request also clears every read bit. Invalidate and pre-invalidate actions are reported one cycle after the bus store, with the line index.

Top module: `spec_violation_detector`

## Requirements
- R1: While reset is asserted and right after it, violation_o, inv_pulse_o and preinv_pulse_o are 0 and every bit of line_valid_o, line_read_o and line_preinv_o is 0.
- R2: A local load (lcl_valid_i=1, lcl_store_i=0) makes its line valid at the next edge. If this thread is not the head, it also sets that line's read bit. load_hit_o is 1 in the same cycle when the requested line is already valid.
- R3: A local store (lcl_store_i=1) makes its line valid at the next edge and never sets its read bit.
- R4: A processor's rank is (id - head_i) mod NUM_CPU, and rank 0 is the head. A writer whose rank is lower than this processor's is earlier, and one whose rank is higher is later. Bus stores that carry this processor's own id (MY_ID) have no effect.
- R5: A bus store from an earlier writer to a valid line clears that line's valid and pre-invalidate bits at the next edge. In the same cycle, inv_pulse_o=1 and inv_line_o holds the line index.
- R6: If the line hit under R5 has its read bit set and this thread is not the head, violation_o becomes 1 at the next edge.
- R7: A bus store from a later writer to a valid line sets its pre-invalidate bit and leaves it valid. The next cycle shows preinv_pulse_o=1 with preinv_line_o. Such a store never raises a violation.
- R8: When commit_req_i or restart_req_i is 1, the next edge clears all read bits, invalidates every pre-invalidated line and clears all pre-invalidate bits.
- R9: violation_o stays 1 until restart_ack_i is sampled at 1. A new violation in the same cycle as the acknowledge keeps it at 1.
- R10: When a bus store and a local load hit the same line in one cycle, the bus store takes effect first. The load therefore refills the line and sets its read bit, and no violation results from that load.
- R11: Violations can only be flagged while head_i differs from MY_ID. A load made while this thread is the head sets no read bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| head_i | input | ID_W | Processor number of the non-speculative thread |
| lcl_valid_i | input | 1 | Local access request this cycle |
| lcl_store_i | input | 1 | 1 = local store, 0 = local load |
| lcl_line_i | input | IDX_W | Line index of the local access |
| bus_valid_i | input | 1 | Store broadcast on the write bus this cycle |
| bus_cpu_i | input | ID_W | Processor number of the bus writer |
| bus_line_i | input | IDX_W | Line index of the bus store |
| commit_req_i | input | 1 | This thread commits |
| restart_req_i | input | 1 | This thread restarts after a violation |
| restart_ack_i | input | 1 | Restart acknowledged, clears the violation flag |
| load_hit_o | output | 1 | Current local load hits a valid line |
| violation_o | output | 1 | Sticky read-after-write violation |
| inv_pulse_o | output | 1 | A line was invalidated by an earlier writer last cycle |
| inv_line_o | output | IDX_W | Line index of that invalidation |
| preinv_pulse_o | output | 1 | A line was pre-invalidated by a later writer last cycle |
| preinv_line_o | output | IDX_W | Line index of that pre-invalidation |
| line_valid_o | output | NUM_LINES | Valid bit of every line |
| line_read_o | output | NUM_LINES | Speculative read bit of every line |
| line_preinv_o | output | NUM_LINES | Pre-invalidate bit of every line |

## Verification
The bench builds the block with NUM_CPU=4, NUM_LINES=8 and MY_ID=2. With processor 2 as the observed thread, moving the head pointer through 0, 2 and 3 places both earlier and later writers on either side of it, and also makes it the head. Eight lines are few enough to compare the whole valid, read and pre-invalidate vectors after every step. They are also enough to keep several lines in different states at once, so a wrong line index shows up at once. The vectors cover a load and a bus store colliding on one line, and an acknowledge that arrives together with a new violation.

// File: rtl/spec_pkg.sv
package spec_pkg;

  // Distance of a processor from the head thread, modulo the processor count.
  function automatic int unsigned thread_rank(int unsigned cpu, int unsigned head,
                                              int unsigned ncpu);
    return (cpu + ncpu - head) % ncpu;
  endfunction

  // True when a thread of rank a runs before one of rank b.
  function automatic logic rank_before(int unsigned a, int unsigned b);
    return a < b;
  endfunction

endpackage

// File: rtl/spec_order.sv
module spec_order #(
  parameter int unsigned NUM_CPU = 4,
  parameter int unsigned MY_ID   = 0,
  localparam int unsigned ID_W   = $clog2(NUM_CPU)
) (
  input  logic [ID_W-1:0] head_i,
  input  logic            bus_valid_i,
  input  logic [ID_W-1:0] bus_cpu_i,
  output logic            is_head_o,
  output logic            writer_earlier_o,
  output logic            writer_later_o
);
  import spec_pkg::*;

  int unsigned my_rank;
  int unsigned wr_rank;
  logic        foreign;

  always_comb begin
    my_rank          = thread_rank(MY_ID, 32'(head_i), NUM_CPU);
    wr_rank          = thread_rank(32'(bus_cpu_i), 32'(head_i), NUM_CPU);
    foreign          = bus_valid_i && (bus_cpu_i != ID_W'(MY_ID));
    is_head_o        = (my_rank == 0);
    writer_earlier_o = foreign && rank_before(wr_rank, my_rank);
    writer_later_o   = foreign && rank_before(my_rank, wr_rank);
  end

endmodule

// File: rtl/spec_line_state.sv
module spec_line_state (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic early_i,     // earlier writer stored to this valid line
  input  logic late_i,      // later writer stored to this valid line
  input  logic clr_i,       // commit or restart epoch boundary
  input  logic touch_i,     // local access to this line
  input  logic mark_read_i, // access is a speculative load
  output logic valid_o,
  output logic read_o,
  output logic preinv_o
);
  logic v_d, r_d, p_d;

  // Ordering inside one cycle: bus store, then epoch clear, then local access.
  always_comb begin
    v_d = valid_o;
    r_d = read_o;
    p_d = preinv_o;
    if (early_i) begin
      v_d = 1'b0;
      p_d = 1'b0;
    end
    if (late_i) p_d = 1'b1;
    if (clr_i) begin
      v_d = v_d & ~p_d;
      p_d = 1'b0;
      r_d = 1'b0;
    end
    if (touch_i) begin
      v_d = 1'b1;
      if (mark_read_i) r_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      read_o   <= 1'b0;
      preinv_o <= 1'b0;
    end else begin
      valid_o  <= v_d;
      read_o   <= r_d;
      preinv_o <= p_d;
    end
  end

endmodule

// File: rtl/spec_sticky_flag.sv
module spec_sticky_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clear_i,
  output logic flag_o
);
  // A set in the same cycle as a clear wins.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_o <= 1'b0;
    else         flag_o <= set_i | (flag_o & ~clear_i);
  end
endmodule

// File: rtl/spec_violation_detector.sv
module spec_violation_detector #(
  parameter int unsigned NUM_CPU   = 4,
  parameter int unsigned NUM_LINES = 8,
  parameter int unsigned MY_ID     = 0,
  localparam int unsigned ID_W     = $clog2(NUM_CPU),
  localparam int unsigned IDX_W    = $clog2(NUM_LINES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ID_W-1:0]      head_i,
  input  logic                 lcl_valid_i,
  input  logic                 lcl_store_i,
  input  logic [IDX_W-1:0]     lcl_line_i,
  input  logic                 bus_valid_i,
  input  logic [ID_W-1:0]      bus_cpu_i,
  input  logic [IDX_W-1:0]     bus_line_i,
  input  logic                 commit_req_i,
  input  logic                 restart_req_i,
  input  logic                 restart_ack_i,
  output logic                 load_hit_o,
  output logic                 violation_o,
  output logic                 inv_pulse_o,
  output logic [IDX_W-1:0]     inv_line_o,
  output logic                 preinv_pulse_o,
  output logic [IDX_W-1:0]     preinv_line_o,
  output logic [NUM_LINES-1:0] line_valid_o,
  output logic [NUM_LINES-1:0] line_read_o,
  output logic [NUM_LINES-1:0] line_preinv_o
);

  // Named internal events, also seen by the bound checker.
  logic                 is_head;
  logic                 writer_earlier;
  logic                 writer_later;
  logic                 epoch_clr;
  logic                 raw_any;
  logic                 spec_load;
  logic [NUM_LINES-1:0] early_hit;
  logic [NUM_LINES-1:0] late_hit;
  logic [NUM_LINES-1:0] touch_vec;
  logic [NUM_LINES-1:0] raw_vec;

  spec_order #(
    .NUM_CPU (NUM_CPU),
    .MY_ID   (MY_ID)
  ) u_order (
    .head_i           (head_i),
    .bus_valid_i      (bus_valid_i),
    .bus_cpu_i        (bus_cpu_i),
    .is_head_o        (is_head),
    .writer_earlier_o (writer_earlier),
    .writer_later_o   (writer_later)
  );

  assign epoch_clr = commit_req_i | restart_req_i;
  assign spec_load = !lcl_store_i && !is_head;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic bus_sel;
    assign bus_sel      = (bus_line_i == IDX_W'(g)) && line_valid_o[g];
    assign early_hit[g] = writer_earlier && bus_sel;
    assign late_hit[g]  = writer_later && bus_sel;
    assign touch_vec[g] = lcl_valid_i && (lcl_line_i == IDX_W'(g));
    assign raw_vec[g]   = early_hit[g] && line_read_o[g] && !is_head;

    spec_line_state u_line (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .early_i     (early_hit[g]),
      .late_i      (late_hit[g]),
      .clr_i       (epoch_clr),
      .touch_i     (touch_vec[g]),
      .mark_read_i (spec_load),
      .valid_o     (line_valid_o[g]),
      .read_o      (line_read_o[g]),
      .preinv_o    (line_preinv_o[g])
    );
  end

  assign raw_any = |raw_vec;

  spec_sticky_flag u_flag (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (raw_any),
    .clear_i (restart_ack_i),
    .flag_o  (violation_o)
  );

  assign load_hit_o = lcl_valid_i && !lcl_store_i && line_valid_o[lcl_line_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inv_pulse_o    <= 1'b0;
      inv_line_o     <= '0;
      preinv_pulse_o <= 1'b0;
      preinv_line_o  <= '0;
    end else begin
      inv_pulse_o    <= |early_hit;
      preinv_pulse_o <= |late_hit;
      if (|early_hit) inv_line_o    <= bus_line_i;
      if (|late_hit)  preinv_line_o <= bus_line_i;
    end
  end

endmodule

// File: rtl/spec_violation_detector_chk.sv
module spec_violation_detector_chk #(
  parameter int unsigned NUM_CPU   = 4,
  parameter int unsigned NUM_LINES = 8,
  parameter int unsigned MY_ID     = 0,
  localparam int unsigned ID_W     = $clog2(NUM_CPU),
  localparam int unsigned IDX_W    = $clog2(NUM_LINES)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [ID_W-1:0]      head_i,
  input logic                 lcl_valid_i,
  input logic                 lcl_store_i,
  input logic [IDX_W-1:0]     lcl_line_i,
  input logic                 bus_valid_i,
  input logic [ID_W-1:0]      bus_cpu_i,
  input logic [IDX_W-1:0]     bus_line_i,
  input logic                 commit_req_i,
  input logic                 restart_req_i,
  input logic                 restart_ack_i,
  input logic                 violation_o,
  input logic                 inv_pulse_o,
  input logic [IDX_W-1:0]     inv_line_o,
  input logic                 preinv_pulse_o,
  input logic [IDX_W-1:0]     preinv_line_o,
  input logic [NUM_LINES-1:0] line_valid_o,
  input logic [NUM_LINES-1:0] line_read_o,
  input logic [NUM_LINES-1:0] line_preinv_o,
  input logic                 writer_earlier,
  input logic                 raw_any
);

  // R9: the flag holds without an acknowledge
  assert_viol_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    violation_o && !restart_ack_i |=> violation_o);

  // R9: an acknowledge with no new hazard clears the flag
  assert_ack_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_ack_i && !raw_any |=> !violation_o);

  // R6, R7: a violation rises only after a store from an earlier writer
  assert_viol_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(violation_o) |-> $past(bus_valid_i && writer_earlier));

  // R11: the head thread is never flagged
  assert_head_safe_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(violation_o) |-> ($past(head_i) != ID_W'(MY_ID)));

  // R8: an epoch boundary clears read bits unless a load refills one
  assert_read_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_req_i || restart_req_i) && !(lcl_valid_i && !lcl_store_i)
    |=> (line_read_o == '0));

  // R8: an epoch boundary leaves no pre-invalidated line
  assert_preinv_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_req_i || restart_req_i) |=> (line_preinv_o == '0));

  // R5, R7: a store is either earlier or later, never both
  assert_one_action_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(inv_pulse_o && preinv_pulse_o));

  // R5: an invalidated line is gone unless a local access refilled it
  assert_inv_drops_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_pulse_o && !$past(lcl_valid_i && (lcl_line_i == bus_line_i))
    |-> !line_valid_o[inv_line_o]);

  // R7: a pre-invalidated line stays valid and marked within the epoch
  assert_preinv_keeps_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    preinv_pulse_o && !$past(commit_req_i || restart_req_i)
    |-> line_valid_o[preinv_line_o] && line_preinv_o[preinv_line_o]);

  // R4: stores carrying this processor's own id cause no action
  assert_own_ignored_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_i && (bus_cpu_i == ID_W'(MY_ID)) |=> !inv_pulse_o && !preinv_pulse_o);

endmodule

bind spec_violation_detector spec_violation_detector_chk #(
  .NUM_CPU   (NUM_CPU),
  .NUM_LINES (NUM_LINES),
  .MY_ID     (MY_ID)
) chk_i (.*);

// File: tb/spec_violation_detector_tb_top.sv
module spec_violation_detector_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NCPU  = 4;
  localparam int NLINE = 8;
  localparam int ME    = 2;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] head_i = '0;
  logic       lcl_valid_i = 1'b0, lcl_store_i = 1'b0;
  logic [2:0] lcl_line_i = '0;
  logic       bus_valid_i = 1'b0;
  logic [1:0] bus_cpu_i = '0;
  logic [2:0] bus_line_i = '0;
  logic       commit_req_i = 1'b0, restart_req_i = 1'b0, restart_ack_i = 1'b0;
  logic       load_hit_o, violation_o, inv_pulse_o, preinv_pulse_o;
  logic [2:0] inv_line_o, preinv_line_o;
  logic [7:0] line_valid_o, line_read_o, line_preinv_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  spec_violation_detector #(.NUM_CPU(NCPU), .NUM_LINES(NLINE), .MY_ID(ME)) dut_i (.*);

  typedef struct packed {
    logic [1:0] head;
    logic       lv;
    logic       ls;
    logic [2:0] ll;
    logic       bv;
    logic [1:0] bid;
    logic [2:0] bl;
    logic       cm;
    logic       rs;
    logic       ak;
    logic       ev;
    logic [7:0] evalid;
    logic [7:0] eread;
    logic [7:0] epre;
    logic [3:0] req;
  } vec_t;

  localparam int NVEC = 17;
  // Processor 2 is observed. head 0: ranks cpu0=0, cpu1=1, me=2, cpu3=3.
  // head 3: cpu3=0, cpu0=1, cpu1=2, me=3.
  localparam vec_t VECS [NVEC] = '{
    '{2'd0,1'b1,1'b0,3'd3, 1'b0,2'd0,3'd0, 1'b0,1'b0,1'b0, 1'b0,8'h08,8'h08,8'h00, 4'd2},  // R2 load
    '{2'd0,1'b1,1'b1,3'd5, 1'b0,2'd0,3'd0, 1'b0,1'b0,1'b0, 1'b0,8'h28,8'h08,8'h00, 4'd3},  // R3 store
    '{2'd0,1'b1,1'b0,3'd1, 1'b0,2'd0,3'd0, 1'b0,1'b0,1'b0, 1'b0,8'h2A,8'h0A,8'h00, 4'd2},  // R2 load
    '{2'd0,1'b0,1'b0,3'd0, 1'b1,2'd3,3'd3, 1'b0,1'b0,1'b0, 1'b0,8'h2A,8'h0A,8'h08, 4'd7},  // R7 later writer
    '{2'd0,1'b0,1'b0,3'd0, 1'b1,2'd2,3'd1, 1'b0,1'b0,1'b0, 1'b0,8'h2A,8'h0A,8'h08, 4'd4},  // R4 own id
    '{2'd0,1'b0,1'b0,3'd0, 1'b1,2'd1,3'd5, 1'b0,1'b0,1'b0, 1'b0,8'h0A,8'h0A,8'h08, 4'd5},  // R5 no read bit
    '{2'd0,1'b0,1'b0,3'd0, 1'b1,2'd0,3'd1, 1'b0,1'b0,1'b0, 1'b1,8'h08,8'h0A,8'h08, 4'd6},  // R6 hazard
    '{2'd0,1'b0,1'b0,3'd0, 1'b0,2'd0,3'd0, 1'b0,1'b0,1'b1, 1'b0,8'h08,8'h0A,8'h08, 4'd9},  // R9 ack
    '{2'd0,1'b0,1'b0,3'd0, 1'b0,2'd0,3'd0, 1'b1,1'b0,1'b0, 1'b0,8'h00,8'h00,8'h00, 4'd8},  // R8 commit
    '{2'd2,1'b1,1'b0,3'd4, 1'b0,2'd0,3'd0, 1'b0,1'b0,1'b0, 1'b0,8'h10,8'h00,8'h00, 4'd11}, // R11 head load
    '{2'd2,1'b0,1'b0,3'd0, 1'b1,2'd3,3'd4, 1'b0,1'b0,1'b0, 1'b0,8'h10,8'h00,8'h10, 4'd4},  // R4 head: all later
    '{2'd3,1'b0,1'b0,3'd0, 1'b1,2'd1,3'd4, 1'b0,1'b0,1'b0, 1'b0,8'h00,8'h00,8'h00, 4'd5},  // R5 clears preinv
    '{2'd3,1'b1,1'b1,3'd6, 1'b0,2'd0,3'd0, 1'b0,1'b0,1'b0, 1'b0,8'h40,8'h00,8'h00, 4'd3},  // R3 store
    '{2'd3,1'b1,1'b0,3'd6, 1'b1,2'd0,3'd6, 1'b0,1'b0,1'b0, 1'b0,8'h40,8'h40,8'h00, 4'd10}, // R10 bus first
    '{2'd3,1'b0,1'b0,3'd0, 1'b1,2'd1,3'd6, 1'b0,1'b0,1'b0, 1'b1,8'h00,8'h40,8'h00, 4'd6},  // R6 hazard
    '{2'd3,1'b0,1'b0,3'd0, 1'b0,2'd0,3'd0, 1'b0,1'b1,1'b0, 1'b1,8'h00,8'h00,8'h00, 4'd8},  // R8 restart
    '{2'd3,1'b0,1'b0,3'd0, 1'b0,2'd0,3'd0, 1'b0,1'b0,1'b1, 1'b0,8'h00,8'h00,8'h00, 4'd9}   // R9 ack
  };

  task automatic check(string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic idle();
    lcl_valid_i = 1'b0; lcl_store_i = 1'b0; lcl_line_i = '0;
    bus_valid_i = 1'b0; bus_cpu_i = '0; bus_line_i = '0;
    commit_req_i = 1'b0; restart_req_i = 1'b0; restart_ack_i = 1'b0;
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic local_op(logic st, logic [2:0] ln);
    idle();
    lcl_valid_i = 1'b1; lcl_store_i = st; lcl_line_i = ln;
    tick();
  endtask

  task automatic bus_op(logic [1:0] id, logic [2:0] ln);
    idle();
    bus_valid_i = 1'b1; bus_cpu_i = id; bus_line_i = ln;
    tick();
  endtask

  initial begin
    idle();
    repeat (3) @(negedge clk_i);
    // R1 reset state while held
    check("R1 violation in reset", 32'(violation_o), 0);
    check("R1 valid in reset", 32'(line_valid_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 read after reset", 32'(line_read_o), 0);
    check("R1 preinv after reset", 32'(line_preinv_o), 0);
    check("R1 pulses after reset", 32'({inv_pulse_o, preinv_pulse_o}), 0);

    for (int i = 0; i < NVEC; i++) begin
      head_i        = VECS[i].head;
      lcl_valid_i   = VECS[i].lv;
      lcl_store_i   = VECS[i].ls;
      lcl_line_i    = VECS[i].ll;
      bus_valid_i   = VECS[i].bv;
      bus_cpu_i     = VECS[i].bid;
      bus_line_i    = VECS[i].bl;
      commit_req_i  = VECS[i].cm;
      restart_req_i = VECS[i].rs;
      restart_ack_i = VECS[i].ak;
      tick();
      check($sformatf("R%0d vec %0d violation", VECS[i].req, i), 32'(violation_o), 32'(VECS[i].ev));
      check($sformatf("R%0d vec %0d valid", VECS[i].req, i), 32'(line_valid_o), 32'(VECS[i].evalid));
      check($sformatf("R%0d vec %0d read", VECS[i].req, i), 32'(line_read_o), 32'(VECS[i].eread));
      check($sformatf("R%0d vec %0d preinv", VECS[i].req, i), 32'(line_preinv_o), 32'(VECS[i].epre));
    end

    // R2 load hit reported in the same cycle (head 3, this thread speculative)
    local_op(1'b1, 3'd2);
    idle();
    lcl_valid_i = 1'b1; lcl_line_i = 3'd2;
    #1 check("R2 load_hit on valid line", 32'(load_hit_o), 1);
    lcl_line_i = 3'd0;
    #1 check("R2 load_hit on invalid line", 32'(load_hit_o), 0);
    lcl_line_i = 3'd2;
    tick();                       // load of line 2 sets its read bit
    // R5 and R6: earlier writer cpu1 hits the read line
    bus_op(2'd1, 3'd2);
    check("R5 inv_pulse", 32'(inv_pulse_o), 1);
    check("R5 inv_line", 32'(inv_line_o), 2);
    check("R6 violation raised", 32'(violation_o), 1);
    // R9 acknowledge together with a new hazard keeps the flag
    local_op(1'b0, 3'd2);
    idle();
    restart_ack_i = 1'b1; bus_valid_i = 1'b1; bus_cpu_i = 2'd0; bus_line_i = 3'd2;
    tick();
    check("R9 ack with new hazard", 32'(violation_o), 1);
    idle();
    restart_ack_i = 1'b1;
    tick();
    check("R9 plain ack", 32'(violation_o), 0);
    // R7 later writer under head 0: cpu3 pre-invalidates
    head_i = 2'd0;
    local_op(1'b0, 3'd0);
    bus_op(2'd3, 3'd0);
    check("R7 preinv_pulse", 32'(preinv_pulse_o), 1);
    check("R7 preinv_line", 32'(preinv_line_o), 0);
    check("R7 no inv_pulse", 32'(inv_pulse_o), 0);
    check("R7 line stays valid", 32'(line_valid_o[0]), 1);
    check("R7 no violation", 32'(violation_o), 0);
    idle();
    tick();
    check("R5 pulse lasts one cycle", 32'(inv_pulse_o | preinv_pulse_o), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule